// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands by repeated conditional addition. A start pulse captures both operands. The multiplicand goes into the low half of a register twice its width, with the upper half zeroed. The multiplier goes into a right-shifting register, and the product register is cleared.

After that, the block performs one iteration per clock. Each iteration looks at the low bit of the multiplier. When that bit is set, the current multiplicand value is added into the product; when it is clear, the product keeps its value. On the same edge the multiplicand shifts one place left and the multiplier one place right.

After as many iterations as the multiplier has bits, the block raises a one-cycle completion pulse and drops its busy flag. The result stays on the product output until the next operation starts.

Top module: `shift_add_mul`

## Requirements
- R1: While rst_ni is low and on the first cycle after its release, busy_o and done_o are 0 and product_o is 0.
- R2: A start_i sampled high while busy_o is low loads the operands; from the next cycle busy_o is 1 and product_o is 0.
- R3: Each busy cycle adds the left-shifted multiplicand into product_o if the current multiplier low bit is 1, else leaves it unchanged; for multiplicand 2 and multiplier 11 the successive products are 2, 6, 6, 22.
- R4: An operation holds busy_o high for exactly 4 cycles after the load; in the next cycle done_o is 1 for one cycle and busy_o is 0.
- R5: When done_o is 1, product_o equals the 8-bit unsigned product of the captured 4-bit operands, for every one of the 256 operand pairs.
- R6: start_i while busy_o is 1 is ignored: operands and progress of the running operation are unaffected.
- R7: start_i sampled high in the cycle done_o is 1 starts a new operation, clearing product_o on the next cycle.
- R8: After done_o, product_o holds its value and done_o stays 0 until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a multiply |
| mcand_i | input | 4 | Multiplicand operand |
| mplier_i | input | 4 | Multiplier operand |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 8 | Product register |

## Verification
The completion cycle and a new load can coincide. This happens when start_i is held high in the very cycle that done_o pulses. The bench provokes it on purpose, then judges two things: the next cycle must show busy_o high and a cleared product, and the following run must reach its own correct product. A start request is also raised in the middle of a running operation. The bench then checks that the result still matches the original operands and that the done pulse arrives on schedule.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_mcand_reg.sv
module mul_mcand_reg #(
  parameter int unsigned IN_W  = 4,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [IN_W-1:0]  mcand_i,
  output logic [REG_W-1:0] mcand_o
);
  localparam int unsigned PAD_W = REG_W - IN_W;

  logic [REG_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= {{PAD_W{1'b0}}, mcand_i};
    else if (step_i) q <= {q[REG_W-2:0], 1'b0};
  end

  assign mcand_o = q;
endmodule

// File: rtl/mul_mplier_reg.sv
module mul_mplier_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mplier_i,
  output logic         lsb_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= mplier_i;
    else if (step_i) q <= {1'b0, q[W-1:1]};
  end

  assign lsb_o = q[0];
endmodule

// File: rtl/mul_accum.sv
module mul_accum #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic         add_en_i,
  input  logic [W-1:0] addend_i,
  output logic [W-1:0] prod_o
);
  logic [W-1:0] q;
  logic [W-1:0] sum;

  assign sum = q + addend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   q <= '0;
    else if (clear_i)              q <= '0;
    else if (step_i && add_en_i)   q <= sum;
  end

  assign prod_o = q;
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int unsigned ITER = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

  mul_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = start_i && (state_q != ST_RUN);
  assign step_o = (state_q == ST_RUN);
  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (cnt_q == LAST) state_d = ST_FIN;
      ST_FIN:  state_d = start_i ? ST_RUN : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o)      cnt_q <= '0;
      else if (step_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int unsigned MCAND_W  = 4,
  parameter int unsigned MPLIER_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [MCAND_W-1:0]            mcand_i,
  input  logic [MPLIER_W-1:0]           mplier_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [MCAND_W+MPLIER_W-1:0]   product_o
);
  localparam int unsigned PROD_W = MCAND_W + MPLIER_W;

  logic              load;
  logic              step;
  logic              mplier_lsb;
  logic [PROD_W-1:0] mcand_q;

  mul_ctrl #(.ITER(MPLIER_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  mul_mcand_reg #(.IN_W(MCAND_W), .REG_W(PROD_W)) u_mcand (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .mcand_i(mcand_i),
    .mcand_o(mcand_q)
  );

  mul_mplier_reg #(.W(MPLIER_W)) u_mplier (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .mplier_i(mplier_i),
    .lsb_o   (mplier_lsb)
  );

  mul_accum #(.W(PROD_W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .step_i  (step),
    .add_en_i(mplier_lsb),
    .addend_i(mcand_q),
    .prod_o  (product_o)
  );
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int unsigned PROD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [PROD_W-1:0] product_o,
  input logic              mplier_lsb_i,
  input logic [PROD_W-1:0] mcand_i
);
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (!busy_o && !done_o && product_o == '0);
    end
  end

  a_r2_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && product_o == '0));

  a_r3_hold_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mplier_lsb_i) |=> $stable(product_o));

  a_r3_grow_on_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mplier_lsb_i) |=> (product_o == $past(product_o) + $past(mcand_i)));

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r6_no_reload_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($countones(mcand_i) == $past($countones(mcand_i))));

  a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));
endmodule

bind shift_add_mul shift_add_mul_chk #(.PROD_W(PROD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .product_o   (product_o),
  .mplier_lsb_i(mplier_lsb),
  .mcand_i     (mcand_q)
);

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [3:0] a;
  logic [3:0] b;
  logic       busy;
  logic       done;
  logic [7:0] prod;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  shift_add_mul u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .mcand_i  (a),
    .mplier_i (b),
    .busy_o   (busy),
    .done_o   (done),
    .product_o(prod)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives start at a negedge; returns at the negedge after the load edge.
  task automatic launch(input int x, input int y);
    start = 1'b1;
    a = 4'(x);
    b = 4'(y);
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    bit ok;
    int exp_p;
    rst_n = 1'b0;
    start = 1'b0;
    a = '0;
    b = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && prod == 0, "R1 reset", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && prod == 0, "R1 after release", int'(prod), 0);

    // R2 / R3: worked example 2 x 11
    launch(2, 11);
    chk(busy && prod == 0, "R2 load", int'(prod), 0);
    @(negedge clk); chk(prod == 2,  "R3 step1", int'(prod), 2);
    @(negedge clk); chk(prod == 6,  "R3 step2", int'(prod), 6);
    @(negedge clk); chk(prod == 6,  "R3 step3 no add", int'(prod), 6);
    @(negedge clk); chk(prod == 22, "R3 step4", int'(prod), 22);
    chk(done && !busy, "R4 done pulse", {done, busy}, 2);
    @(negedge clk);
    chk(!done, "R4 done one cycle", int'(done), 0);

    // R8: result holds
    repeat (3) @(negedge clk);
    chk(prod == 22 && !done && !busy, "R8 hold", int'(prod), 22);

    // R6: start mid-operation ignored
    launch(3, 5);
    @(negedge clk);
    start = 1'b1; a = 4'hF; b = 4'hF;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R6 still busy", int'(busy), 1);
    repeat (2) @(negedge clk);
    chk(done && prod == 15, "R6 original result", int'(prod), 15);

    // R7: start during the done cycle
    start = 1'b1; a = 4'd7; b = 4'd9;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && prod == 0, "R7 restart clears", int'(prod), 0);
    repeat (4) @(negedge clk);
    chk(done && prod == 63, "R7 restart result", int'(prod), 63);
    @(negedge clk);

    // R4 / R5: exhaustive sweep
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        launch(x, y);
        ok = busy && prod == 0;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          ok = ok && busy && !done;
        end
        @(negedge clk);
        exp_p = x * y;
        chk(ok && done && !busy, "R4 timing", {busy, done}, 1);
        chk(prod == 8'(exp_p), "R5 product", int'(prod), exp_p);
        @(negedge clk);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule